// File: doc/BRIEF.md
# Cascadable Delay-and-Sum Receive Beamformer Slice

This block is one slice of a digital receive beamformer. It takes sixteen streams of signed 12-bit echo samples and holds each stream in its own circular buffer. Each channel is read back at a per-channel offset of 0 to 63 samples. The sixteen delayed samples are added in a pipelined tree. The block then adds a partial sum that comes from the previous slice. It drives the total out as a 20-bit signed partial sum for the next slice. With four slices in a chain, a 64-channel beam sum comes out of the last one.

Delay values are loaded between scan lines through a small write port (channel select, value, write strobe). A write lands in a pending register. All pending values move into the active set together when a line-start strobe is given. This lets the controller prepare the next line's focus while the current line is still being received.

A sample word and the cascade word presented in the same valid cycle leave the block together in one output word, 6 cycles later. Because every slice in a chain has the same latency, a chain driven from a common valid and sample clock stays aligned.

Top module: `bf_slice`

## Requirements
- R1: While reset is low and in the first cycle after it, `psum_vld_o` is 0 and `psum_o` is 0. All active and pending delays are reset to 0.
- R2: `psum_vld_o` is high exactly 6 clock cycles after a cycle in which `smp_vld_i` was high, and is low otherwise.
- R3: A valid output word equals the sum of the sixteen delayed channel samples, each taken as signed 12-bit, plus `psum_i`, all as 20-bit two's complement. Full-scale inputs on all 64 cascaded channels do not overflow.
- R4: A channel whose active delay is d contributes the sample it received d valid cycles before the current one. Cycles with `smp_vld_i` low are not counted. A delay of 0 uses the sample of the current cycle.
- R5: A channel whose delay reaches back past the first valid sample since reset contributes 0.
- R6: A delay write (`dly_wr_i` high, channel index on `dly_sel_i`, value on `dly_val_i`) changes nothing at the output until `line_go_i` is pulsed. The line-start strobe makes all pending delays active for samples presented in later cycles. The sample presented in the strobe cycle still uses the old delays.
- R7: A delay write in the same cycle as `line_go_i` goes to the pending set only. It takes effect at the next line-start strobe.
- R8: Channel i occupies bits [12*i+11 : 12*i] of `smp_i`, and `dly_sel_i` = i selects channel i's delay.
- R9: The `psum_i` value presented with a valid sample word is added into that same word's output, not into a neighbour's.
- R10: The maximum delay of 63 works after the write pointer has wrapped the 64-entry buffer many times.
- R11: While `psum_vld_o` is low, `psum_o` keeps the last valid sum.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sample clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| smp_vld_i | input | 1 | Sample word and cascade word are valid |
| smp_i | input | 192 | Sixteen signed 12-bit samples, channel i at bits 12*i+11:12*i |
| psum_i | input | 20 | Signed partial sum from the previous slice |
| dly_wr_i | input | 1 | Write strobe for a pending delay |
| dly_sel_i | input | 4 | Channel index of the delay write |
| dly_val_i | input | 6 | Delay in samples, 0 to 63 |
| line_go_i | input | 1 | Line start: pending delays become active |
| psum_o | output | 20 | Signed partial sum to the next slice |
| psum_vld_o | output | 1 | `psum_o` carries a new sum |

## Verification
A corrupt write pointer or a wrong buffer read offset shows as a wrong sum in the first valid output word that reads the affected channel, 6 cycles after that sample goes in. A ramp with a distinct value per channel makes a wrong channel or a wrong lag visible as a numerical difference. A misaligned valid or cascade pipeline shows as an output word that arrives one cycle early or late, or that carries a neighbouring word's cascade value. Pending or active delay registers that leak shift the sums before the line strobe, or fail to shift them after it. The bench checks both sides of each strobe.

// File: rtl/bf_pkg.sv
package bf_pkg;
    localparam int unsigned BF_CH = 16;  // channels per slice
    localparam int unsigned BF_SW = 12;  // sample width
    localparam int unsigned BF_DW = 6;   // delay field width (depth 2**BF_DW)
    localparam int unsigned BF_CW = 20;  // cascade sum width
endpackage

// File: rtl/bf_dly_regs.sv
module bf_dly_regs #(
    parameter int unsigned NUM_CH = 16,
    parameter int unsigned DW     = 6,
    localparam int unsigned AW    = $clog2(NUM_CH)
) (
    input  logic                 clk_i,
    input  logic                 rst_ni,
    input  logic                 wr_i,
    input  logic [AW-1:0]        sel_i,
    input  logic [DW-1:0]        val_i,
    input  logic                 go_i,
    output logic [NUM_CH*DW-1:0] act_o
);
    typedef struct packed {
        logic [NUM_CH-1:0][DW-1:0] pend;
        logic [NUM_CH-1:0][DW-1:0] act;
    } regs_t;

    regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        // the strobe copies the pending set as it stood before this cycle's write
        if (go_i) r_d.act = r_q.pend;
        if (wr_i) r_d.pend[sel_i] = val_i;
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) r_q <= '0;
        else         r_q <= r_d;
    end

    assign act_o = r_q.act;
endmodule

// File: rtl/bf_chan_dline.sv
module bf_chan_dline #(
    parameter int unsigned SW = 12,
    parameter int unsigned DW = 6,
    localparam int unsigned DEPTH = 1 << DW
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          vld_i,
    input  logic [SW-1:0] smp_i,
    input  logic [DW-1:0] dly_i,
    output logic [SW-1:0] smp_o
);
    typedef struct packed {
        logic [DEPTH-1:0][SW-1:0] ring;
        logic [DW-1:0]            wptr;
        logic [SW-1:0]            rd;
    } dl_t;

    dl_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (vld_i) begin
            s_d.ring[s_q.wptr] = smp_i;
            s_d.wptr           = s_q.wptr + 1'b1;
            s_d.rd             = (dly_i == '0) ? smp_i : s_q.ring[s_q.wptr - dly_i];
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) s_q <= '0;
        else         s_q <= s_d;
    end

    assign smp_o = s_q.rd;
endmodule

// File: rtl/bf_add_tree.sv
module bf_add_tree #(
    parameter int unsigned N  = 16,
    parameter int unsigned IW = 12,
    parameter int unsigned OW = 20,
    localparam int unsigned LEVELS = $clog2(N)
) (
    input  logic            clk_i,
    input  logic            rst_ni,
    input  logic [N*IW-1:0] in_i,
    output logic [OW-1:0]   sum_o
);
    typedef struct packed {
        logic [LEVELS-1:0][N-1:0][OW-1:0] lv;
    } tree_t;

    tree_t t_d, t_q;

    always_comb begin
        t_d = t_q;
        for (int n = 0; n < N/2; n++) begin
            t_d.lv[0][n] = OW'($signed(in_i[(2*n)*IW +: IW]))
                         + OW'($signed(in_i[(2*n+1)*IW +: IW]));
        end
        for (int l = 1; l < LEVELS; l++) begin
            for (int n = 0; n < (N >> (l+1)); n++) begin
                t_d.lv[l][n] = t_q.lv[l-1][2*n] + t_q.lv[l-1][2*n+1];
            end
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) t_q <= '0;
        else         t_q <= t_d;
    end

    assign sum_o = t_q.lv[LEVELS-1][0];
endmodule

// File: rtl/bf_slice.sv
module bf_slice #(
    parameter int unsigned NUM_CH = bf_pkg::BF_CH,
    parameter int unsigned SW     = bf_pkg::BF_SW,
    parameter int unsigned DW     = bf_pkg::BF_DW,
    parameter int unsigned CW     = bf_pkg::BF_CW,
    localparam int unsigned AW     = $clog2(NUM_CH),
    localparam int unsigned LEVELS = $clog2(NUM_CH),
    localparam int unsigned LAT    = LEVELS + 2
) (
    input  logic                 clk_i,
    input  logic                 rst_ni,
    input  logic                 smp_vld_i,
    input  logic [NUM_CH*SW-1:0] smp_i,
    input  logic [CW-1:0]        psum_i,
    input  logic                 dly_wr_i,
    input  logic [AW-1:0]        dly_sel_i,
    input  logic [DW-1:0]        dly_val_i,
    input  logic                 line_go_i,
    output logic [CW-1:0]        psum_o,
    output logic                 psum_vld_o
);
    logic [NUM_CH*DW-1:0] act_dly;
    logic [NUM_CH*SW-1:0] dl_out;
    logic [CW-1:0]        tree_sum;

    bf_dly_regs #(.NUM_CH(NUM_CH), .DW(DW)) u_regs (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .wr_i   (dly_wr_i),
        .sel_i  (dly_sel_i),
        .val_i  (dly_val_i),
        .go_i   (line_go_i),
        .act_o  (act_dly)
    );

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        bf_chan_dline #(.SW(SW), .DW(DW)) u_dl (
            .clk_i  (clk_i),
            .rst_ni (rst_ni),
            .vld_i  (smp_vld_i),
            .smp_i  (smp_i[c*SW +: SW]),
            .dly_i  (act_dly[c*DW +: DW]),
            .smp_o  (dl_out[c*SW +: SW])
        );
    end

    bf_add_tree #(.N(NUM_CH), .IW(SW), .OW(CW)) u_tree (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .in_i   (dl_out),
        .sum_o  (tree_sum)
    );

    // valid and cascade words travel beside the channel stage and the tree
    typedef struct packed {
        logic [LEVELS:0]         vld;
        logic [LEVELS:0][CW-1:0] casc;
        logic [CW-1:0]           out;
        logic                    ov;
    } pipe_t;

    pipe_t p_d, p_q;

    always_comb begin
        p_d      = p_q;
        p_d.vld  = {p_q.vld[LEVELS-1:0], smp_vld_i};
        p_d.casc = {p_q.casc[LEVELS-1:0], psum_i};
        p_d.ov   = p_q.vld[LEVELS];
        if (p_q.vld[LEVELS]) p_d.out = tree_sum + p_q.casc[LEVELS];
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) p_q <= '0;
        else         p_q <= p_d;
    end

    assign psum_o     = p_q.out;
    assign psum_vld_o = p_q.ov;
endmodule

// File: rtl/bf_slice_chk.sv
module bf_slice_chk #(
    parameter int unsigned NUM_CH = 16,
    parameter int unsigned DW     = 6,
    parameter int unsigned CW     = 20,
    parameter int unsigned LAT    = 6
) (
    input logic                 clk_i,
    input logic                 rst_ni,
    input logic                 smp_vld_i,
    input logic                 line_go_i,
    input logic [CW-1:0]        psum_o,
    input logic                 psum_vld_o,
    input logic [NUM_CH*DW-1:0] act_dly
);
    localparam int unsigned CNTW = $clog2(LAT + 1) + 1;
    logic [CNTW-1:0] since_rst;

    always_ff @(posedge clk_i) begin
        if (!rst_ni)                 since_rst <= '0;
        else if (since_rst < CNTW'(LAT)) since_rst <= since_rst + 1'b1;
    end

    a_r1_clear: assert property (@(posedge clk_i)
        $past(!rst_ni) |-> (!psum_vld_o && psum_o == '0));

    a_r2_vld_latency: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (since_rst >= CNTW'(LAT)) |-> (psum_vld_o == $past(smp_vld_i, LAT)));

    a_r6_dly_on_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !$past(line_go_i) |-> $stable(act_dly));

    a_r11_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !psum_vld_o |-> $stable(psum_o));
endmodule

bind bf_slice bf_slice_chk #(
    .NUM_CH (NUM_CH),
    .DW     (DW),
    .CW     (CW),
    .LAT    (LAT)
) u_chk (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .smp_vld_i  (smp_vld_i),
    .line_go_i  (line_go_i),
    .psum_o     (psum_o),
    .psum_vld_o (psum_vld_o),
    .act_dly    (act_dly)
);

// File: tb/bf_slice_tb.sv
module bf_slice_tb;
    localparam int NC = 16;
    localparam int SW = 12;
    localparam int CW = 20;
    localparam int LT = 6;

    logic              clk_i = 1'b0;
    logic              rst_ni = 1'b0;
    logic              smp_vld_i = 1'b0;
    logic [NC*SW-1:0]  smp_i = '0;
    logic [CW-1:0]     psum_i = '0;
    logic              dly_wr_i = 1'b0;
    logic [3:0]        dly_sel_i = '0;
    logic [5:0]        dly_val_i = '0;
    logic              line_go_i = 1'b0;
    logic [CW-1:0]     psum_o;
    logic              psum_vld_o;

    bf_slice u_dut (.*);

    always #2 clk_i = ~clk_i;

    int n_chk = 0, n_bad = 0;
    bit done = 0;

    // reference model
    int hist [NC][1024];
    int nsmp;
    int act [NC];
    int pend [NC];
    bit pv [LT];
    logic [CW-1:0] ps [LT];
    logic [CW-1:0] last_out;
    string tag = "R3";

    typedef struct packed {
        logic [11:0] base;
        logic [11:0] step;
        logic [19:0] casc;
    } vec_t;

    localparam vec_t TBL [8] = '{
        '{12'h001, 12'h001, 20'h00000},
        '{12'h800, 12'h000, 20'hE8000},
        '{12'h7FF, 12'h000, 20'h17FD0},
        '{12'h100, 12'hFF0, 20'hFFFFF},
        '{12'h000, 12'h000, 20'h12345},
        '{12'hFFF, 12'h003, 20'h80000},
        '{12'h555, 12'h0A1, 20'h7FF00},
        '{12'h000, 12'h010, 20'h00007}
    };

    task automatic chk(input bit ok, input string req, input string what,
                       input longint actv, input longint expv);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, actv, expv);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    endtask

    function automatic logic [NC*SW-1:0] ramp(input int k);
        logic [NC*SW-1:0] v;
        for (int c = 0; c < NC; c++) v[c*SW +: SW] = 12'((k*37 + c*211) % 4096);
        return v;
    endfunction

    function automatic logic [NC*SW-1:0] linear(input logic [11:0] b, input logic [11:0] s);
        logic [NC*SW-1:0] v;
        for (int c = 0; c < NC; c++) v[c*SW +: SW] = 12'(b + 12'(c) * s);
        return v;
    endfunction

    task automatic model_clear();
        nsmp = 0;
        last_out = '0;
        for (int c = 0; c < NC; c++) begin act[c] = 0; pend[c] = 0; end
        for (int i = 0; i < LT; i++) begin pv[i] = 0; ps[i] = '0; end
    endtask

    // one clock: drive at negedge, model, edge, check 1 ns later
    task automatic tick(input bit vld, input logic [NC*SW-1:0] smp, input logic [CW-1:0] casc,
                        input bit wr, input int sel, input int val, input bit go);
        int sum;
        logic [CW-1:0] e;
        @(negedge clk_i);
        smp_vld_i = vld; smp_i = smp; psum_i = casc;
        dly_wr_i = wr; dly_sel_i = 4'(sel); dly_val_i = 6'(val); line_go_i = go;
        e = '0;
        if (vld) begin
            sum = $signed(casc);
            for (int c = 0; c < NC; c++) begin
                int cur, d, idx;
                cur = $signed(smp[c*SW +: SW]);
                d = act[c];
                idx = nsmp - d;
                if (d == 0)       sum += cur;
                else if (idx >= 0) sum += hist[c][idx % 1024];
                hist[c][nsmp % 1024] = cur;
            end
            nsmp++;
            e = CW'(sum);
        end
        if (go) for (int c = 0; c < NC; c++) act[c] = pend[c];
        if (wr) pend[sel] = val;
        @(posedge clk_i);
        for (int i = LT-1; i > 0; i--) begin pv[i] = pv[i-1]; ps[i] = ps[i-1]; end
        pv[0] = vld; ps[0] = e;
        #1;
        chk(psum_vld_o == pv[LT-1], "R2", "valid", psum_vld_o, pv[LT-1]);
        if (pv[LT-1]) begin
            chk(psum_o == ps[LT-1], tag, "sum", $signed(psum_o), $signed(ps[LT-1]));
            last_out = ps[LT-1];
        end else begin
            chk(psum_o == last_out, "R11", "hold", $signed(psum_o), $signed(last_out));
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) tick(0, '0, '0, 0, 0, 0, 0);
    endtask

    task automatic do_reset();
        @(negedge clk_i);
        rst_ni = 0; smp_vld_i = 0; dly_wr_i = 0; line_go_i = 0;
        @(posedge clk_i); @(posedge clk_i); #1;
        chk(psum_vld_o == 0, "R1", "reset valid", psum_vld_o, 0);
        chk(psum_o == '0, "R1", "reset sum", psum_o, 0);
        model_clear();
        @(negedge clk_i);
        rst_ni = 1;
    endtask

    initial begin
        #(200000 * 4);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        model_clear();
        do_reset();

        // R3, R8, R9: zero delays, table of patterns, back-to-back words
        tag = "R3";
        for (int i = 0; i < 8; i++) tick(1, linear(TBL[i].base, TBL[i].step), TBL[i].casc, 0, 0, 0, 0);
        idle(8);
        tag = "R9";
        for (int i = 0; i < 8; i++) tick(1, linear(TBL[7-i].base, TBL[7-i].step), TBL[i].casc, 0, 0, 0, 0);
        idle(8);

        // R6: pending writes must not alter sums before the strobe
        tag = "R6";
        for (int c = 0; c < NC; c++) tick(1, ramp(c), CW'(c), 1, c, c*3 + 1, 0);
        for (int k = 0; k < 40; k++) tick(1, ramp(100 + k), '0, 0, 0, 0, 0);
        tick(1, ramp(200), '0, 0, 0, 0, 1);
        tag = "R4";
        for (int k = 0; k < 80; k++) tick(1, ramp(300 + k), CW'(k), 0, 0, 0, 0);
        // R4: gaps in valid are not counted
        for (int k = 0; k < 60; k++) tick((k % 3) != 0, ramp(500 + k), 20'h00100, 0, 0, 0, 0);
        idle(8);

        // R7: write on the strobe cycle lands in pending only
        tag = "R7";
        tick(1, ramp(600), '0, 1, 5, 40, 1);
        for (int k = 0; k < 50; k++) tick(1, ramp(610 + k), '0, 0, 0, 0, 0);
        tick(1, ramp(700), '0, 0, 0, 0, 1);
        for (int k = 0; k < 50; k++) tick(1, ramp(710 + k), '0, 0, 0, 0, 0);
        idle(8);

        // R5, R10: after reset, delay 63 on channel 0 and 9, long stream wraps the ring
        do_reset();
        tick(0, '0, '0, 1, 0, 63, 0);
        tick(0, '0, '0, 1, 9, 63, 0);
        tick(0, '0, '0, 0, 0, 0, 1);
        tag = "R5";
        for (int k = 0; k < 63; k++) tick(1, ramp(900 + k), '0, 0, 0, 0, 0);
        tag = "R10";
        for (int k = 0; k < 200; k++) tick(1, ramp(1000 + k), CW'(k * 5), 0, 0, 0, 0);
        idle(8);

        // R1: reset in the middle of a stream clears the output
        for (int k = 0; k < 3; k++) tick(1, ramp(k), '0, 0, 0, 0, 0);
        do_reset();
        tag = "R3";
        tick(1, linear(12'h800, 12'h000), 20'hE8000, 0, 0, 0, 0);
        idle(8);

        finish_run();
    end
endmodule